// File: doc/BRIEF.md
# Paged Logical Address Translator

This block converts the word address of an unprivileged instruction fetch or operand access into a physical word address. Memory is split into pages of 2^OFF_W words. The low OFF_W bits of the logical address form the offset and the upper bits form the logical page number. A page table in ordinary memory holds one two-word entry per logical page. The entry for page p sits at the table base plus 2·p. Its first word names the physical page, and its second word carries the auxiliary flag bits.

The translator steps through the table entry on a single-port memory master. It checks the access against the page-count limit, the valid flag and the write-permission flag. When every check passes, it sets the reference flag and, for modifying accesses, the dirty flag, and writes the auxiliary word back. When a check fails, it reports an exception with a cause code. In privileged mode the address goes through unchanged and memory is not touched.

A request is accepted while `reqReady` is high. The result arrives with a single-cycle `doneValid` pulse. The memory returns read data on `memRdata` in the cycle after `memEn` is asserted with `memWe` low.

Top module: `page_translator`

## Requirements
- R1: When `privMode` is 1 at acceptance, `physAddr` equals the request address zero-extended. `excValid` stays 0, there is no memory cycle, and `doneValid` rises one cycle after acceptance.
- R2: When not privileged, a logical page number (address >> OFF_W) greater than or equal to `ptLen` raises `excValid` with `excCause` = 1. This holds for fetches and data accesses alike, with no memory cycle, and `doneValid` comes one cycle after acceptance.
- R3: An in-range access reads address `ptBase`+2·p, then `ptBase`+2·p+1. On success `physAddr` = (low PPN_W bits of the first word) · 2^OFF_W + offset, and the upper bits of that word are ignored.
- R4: An entry whose auxiliary bit 2 (valid) is 0 gives `excCause` = 2 for a read, a write or a fetch.
- R5: A write to a valid page whose auxiliary bit 1 (write permission) is 0 gives `excCause` = 3. Reads and fetches of that page succeed. A request with `reqFetch` = 1 is treated as a read whatever `reqWrite` says.
- R6: A successful access sets auxiliary bit 3 (reference). A successful write also sets bit 0 (dirty). All other bits of the auxiliary word keep their values, and the word is written to `ptBase`+2·p+1.
- R7: An access that raises an exception writes nothing. A successful access writes the auxiliary word back only when its value changes.
- R8: `doneValid` is a one-cycle pulse and `excValid` is high only together with it. An in-range access completes 4 cycles after acceptance, or 5 cycles when it writes back. `reqReady` is low while a request is in progress, and no memory cycle happens while `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| privMode | input | 1 | Privileged mode: pass the address through untranslated |
| ptBase | input | MA_W | Physical word address of the page table |
| ptLen | input | LPN_W+1 | Number of logical pages the table covers |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqAddr | input | LA_W | Logical word address |
| reqWrite | input | 1 | Access modifies the page |
| reqFetch | input | 1 | Access is an instruction fetch (read) |
| reqReady | output | 1 | Translator idle and able to accept |
| memEn | output | 1 | Memory cycle enable |
| memWe | output | 1 | Memory cycle is a write |
| memAddr | output | MA_W | Memory word address |
| memWdata | output | WORD_W | Memory write data |
| memRdata | input | WORD_W | Memory read data, one cycle after a read |
| doneValid | output | 1 | Result pulse |
| excValid | output | 1 | Result is an exception |
| excCause | output | 2 | 1 limit, 2 invalid page, 3 write protected |
| physAddr | output | MA_W | Translated physical word address |

## Verification
The bench builds the translator with OFF_W=4, PPN_W=5, LPN_W=4 and WORD_W=8. This gives 16-word pages, 256 logical addresses and a 512-word physical space. Every logical address can therefore be swept as a read, a write and a fetch-with-write-strobe, under table configurations that vary the base, the valid and write-permission patterns, and page counts of 16, 10, 1 and 0. The narrow configuration also leaves spare bits above the page number and the flag nibble, so that garbage placed there exposes any decoding or write-back that touches them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Auxiliary word flag positions (decoded by system software as well)
  localparam int REF_BIT   = 3;
  localparam int VALID_BIT = 2;
  localparam int WP_BIT    = 1;
  localparam int DIRTY_BIT = 0;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_LIMIT   = 2'd1,
    CAUSE_INVALID = 2'd2,
    CAUSE_WPROT   = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_PPN,
    ST_RD_AUX,
    ST_CHECK,
    ST_WB,
    ST_DONE
  } walk_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;       // latch request, pass-through and limit result
    logic capPpn;       // latch physical page word
    logic latchResult;  // latch checks and new auxiliary word
    logic selAux;       // memory address points at the auxiliary word
  } walk_strobe_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int PPN_W  = 7,
  parameter int LPN_W  = 7,
  parameter int WORD_W = 16,
  localparam int LA_W  = LPN_W + OFF_W,
  localparam int MA_W  = PPN_W + OFF_W,
  localparam int LEN_W = LPN_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_strobe_t      stb,
  input  logic              privMode,
  input  logic [MA_W-1:0]   ptBase,
  input  logic [LEN_W-1:0]  ptLen,
  input  logic [LA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [WORD_W-1:0] memRdata,
  output logic              limitHit,
  output logic              needWb,
  output logic [MA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [MA_W-1:0]   physAddr,
  output logic [1:0]        excCause
);

  logic [LA_W-1:0]   addrQ;
  logic              wrQ;
  logic [PPN_W-1:0]  ppnQ;
  logic [WORD_W-1:0] newAuxQ;
  logic [MA_W-1:0]   physQ;
  cause_e            causeQ;

  logic [LPN_W-1:0]  reqLpn;
  logic [MA_W-1:0]   entryBase;
  logic [WORD_W-1:0] auxNext;
  cause_e            faultCause;

  assign reqLpn   = reqAddr[LA_W-1:OFF_W];
  assign limitHit = ({1'b0, reqLpn} >= ptLen);

  assign entryBase = ptBase + MA_W'({addrQ[LA_W-1:OFF_W], 1'b0});
  assign memAddr   = entryBase + MA_W'(stb.selAux);
  assign memWdata  = newAuxQ;

  // Checks and flag update on the auxiliary word as it returns
  always_comb begin
    if (!memRdata[VALID_BIT])                 faultCause = CAUSE_INVALID;
    else if (wrQ && !memRdata[WP_BIT])        faultCause = CAUSE_WPROT;
    else                                      faultCause = CAUSE_NONE;
    auxNext            = memRdata;
    auxNext[REF_BIT]   = 1'b1;
    if (wrQ) auxNext[DIRTY_BIT] = 1'b1;
  end

  assign needWb = (faultCause == CAUSE_NONE) && (auxNext != memRdata);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrQ     <= 1'b0;
      ppnQ    <= '0;
      newAuxQ <= '0;
      physQ   <= '0;
      causeQ  <= CAUSE_NONE;
    end else begin
      if (stb.capReq) begin
        addrQ  <= reqAddr;
        wrQ    <= reqWrite && !reqFetch;
        physQ  <= MA_W'(reqAddr);
        causeQ <= (!privMode && limitHit) ? CAUSE_LIMIT : CAUSE_NONE;
      end
      if (stb.capPpn) ppnQ <= memRdata[PPN_W-1:0];
      if (stb.latchResult) begin
        causeQ  <= faultCause;
        physQ   <= {ppnQ, addrQ[OFF_W-1:0]};
        newAuxQ <= auxNext;
      end
    end
  end

  assign physAddr = physQ;
  assign excCause = causeQ;

endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         privMode,
  input  logic         limitHit,
  input  logic         needWb,
  output walk_strobe_t stb,
  output logic         memEn,
  output logic         memWe,
  output logic         reqReady,
  output logic         doneValid
);

  walk_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    memEn     = 1'b0;
    memWe     = 1'b0;
    reqReady  = 1'b0;
    doneValid = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = (privMode || limitHit) ? ST_DONE : ST_RD_PPN;
        end
      end
      ST_RD_PPN: begin
        memEn     = 1'b1;
        nextState = ST_RD_AUX;
      end
      ST_RD_AUX: begin
        memEn      = 1'b1;
        stb.selAux = 1'b1;
        stb.capPpn = 1'b1;
        nextState  = ST_CHECK;
      end
      ST_CHECK: begin
        stb.latchResult = 1'b1;
        nextState       = needWb ? ST_WB : ST_DONE;
      end
      ST_WB: begin
        memEn      = 1'b1;
        memWe      = 1'b1;
        stb.selAux = 1'b1;
        nextState  = ST_DONE;
      end
      ST_DONE: begin
        doneValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/page_translator.sv
module page_translator
  import ptw_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int PPN_W  = 7,
  parameter int LPN_W  = 7,
  parameter int WORD_W = 16,
  localparam int LA_W  = LPN_W + OFF_W,
  localparam int MA_W  = PPN_W + OFF_W,
  localparam int LEN_W = LPN_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              privMode,
  input  logic [MA_W-1:0]   ptBase,
  input  logic [LEN_W-1:0]  ptLen,
  input  logic              reqValid,
  input  logic [LA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic              reqFetch,
  output logic              reqReady,
  output logic              memEn,
  output logic              memWe,
  output logic [MA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              doneValid,
  output logic              excValid,
  output logic [1:0]        excCause,
  output logic [MA_W-1:0]   physAddr
);

  walk_strobe_t stb;
  logic         limitHit;
  logic         needWb;

  ptw_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .privMode  (privMode),
    .limitHit  (limitHit),
    .needWb    (needWb),
    .stb       (stb),
    .memEn     (memEn),
    .memWe     (memWe),
    .reqReady  (reqReady),
    .doneValid (doneValid)
  );

  ptw_datapath #(
    .OFF_W  (OFF_W),
    .PPN_W  (PPN_W),
    .LPN_W  (LPN_W),
    .WORD_W (WORD_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .privMode (privMode),
    .ptBase   (ptBase),
    .ptLen    (ptLen),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqFetch (reqFetch),
    .memRdata (memRdata),
    .limitHit (limitHit),
    .needWb   (needWb),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .physAddr (physAddr),
    .excCause (excCause)
  );

  assign excValid = doneValid && (excCause != 2'd0);

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int LA_W   = 16,
  parameter int MA_W   = 16,
  parameter int OFF_W  = 9,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              privMode,
  input logic [LEN_W-1:0]  ptLen,
  input logic              reqValid,
  input logic [LA_W-1:0]   reqAddr,
  input logic              reqReady,
  input logic              memEn,
  input logic              memWe,
  input logic [WORD_W-1:0] memWdata,
  input logic              doneValid,
  input logic              excValid,
  input logic [1:0]        excCause,
  input logic [MA_W-1:0]   physAddr
);

  logic [MA_W-1:0] reqAddrExt;
  logic            limitNow;
  logic            takePriv;
  logic            takeLimit;

  assign reqAddrExt = MA_W'(reqAddr);
  assign limitNow   = ({1'b0, reqAddr[LA_W-1:OFF_W]} >= ptLen);
  assign takePriv   = reqReady && reqValid && privMode;
  assign takeLimit  = reqReady && reqValid && !privMode && limitNow;

  assert_priv_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    takePriv |=> (doneValid && !excValid && physAddr == $past(reqAddrExt)));

  assert_limit_exc_R2: assert property (@(posedge clk) disable iff (!rstN)
    takeLimit |=> (excValid && excCause == 2'd1));

  assert_exc_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (doneValid && excCause != 2'd0));

  assert_wb_ref_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memWdata[3]);

  assert_wb_final_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> doneValid);

  assert_mem_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> !reqReady);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

bind page_translator ptw_checker #(
  .LA_W   (LA_W),
  .MA_W   (MA_W),
  .OFF_W  (OFF_W),
  .WORD_W (WORD_W),
  .LEN_W  (LEN_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .privMode  (privMode),
  .ptLen     (ptLen),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqReady  (reqReady),
  .memEn     (memEn),
  .memWe     (memWe),
  .memWdata  (memWdata),
  .doneValid (doneValid),
  .excValid  (excValid),
  .excCause  (excCause),
  .physAddr  (physAddr)
);

// File: tb/sim_page_translator.sv
module sim_page_translator;

  localparam int OFF_W  = 4;
  localparam int PPN_W  = 5;
  localparam int LPN_W  = 4;
  localparam int WORD_W = 8;
  localparam int LA_W   = LPN_W + OFF_W;
  localparam int MA_W   = PPN_W + OFF_W;
  localparam int LEN_W  = LPN_W + 1;
  localparam int NPAGE  = 1 << LPN_W;

  logic clk = 1'b0;
  logic rstN;
  always #10 clk = ~clk;

  logic              privMode, reqValid, reqWrite, reqFetch, reqReady;
  logic [MA_W-1:0]   ptBase;
  logic [LEN_W-1:0]  ptLen;
  logic [LA_W-1:0]   reqAddr;
  logic              memEn, memWe, doneValid, excValid;
  logic [MA_W-1:0]   memAddr, physAddr;
  logic [WORD_W-1:0] memWdata;
  logic [WORD_W-1:0] memRdata = '0;
  logic [1:0]        excCause;

  page_translator #(.OFF_W(OFF_W), .PPN_W(PPN_W), .LPN_W(LPN_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rstN(rstN), .privMode(privMode), .ptBase(ptBase), .ptLen(ptLen),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .reqReady(reqReady), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .doneValid(doneValid),
    .excValid(excValid), .excCause(excCause), .physAddr(physAddr)
  );

  // Memory model with a bench load path
  logic [WORD_W-1:0] mem [0:(1<<MA_W)-1];
  logic              ldEn = 1'b0;
  logic [MA_W-1:0]   ldAddr = '0;
  logic [WORD_W-1:0] ldData = '0;
  int                rdCnt = 0;
  int                wrCnt = 0;
  logic [MA_W-1:0]   prevRd = '0, lastRd = '0, lastWr = '0;

  always @(posedge clk) begin
    if (ldEn) mem[ldAddr] <= ldData;
    else if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        wrCnt  <= wrCnt + 1;
        lastWr <= memAddr;
      end else begin
        memRdata <= mem[memAddr];
        rdCnt    <= rdCnt + 1;
        prevRd   <= lastRd;
        lastRd   <= memAddr;
      end
    end
  end

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [WORD_W-1:0] expAux [NPAGE];
  logic [PPN_W-1:0]  expPpn [NPAGE];
  int                curLen;
  int                curBase;

  task automatic poke(input int a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldAddr = MA_W'(a); ldData = d;
    @(posedge clk); #1;
    ldEn = 1'b0;
  endtask

  task automatic loadConfig(input int k);
    curBase = 40 + 100 * k;
    curLen  = (k == 0) ? 16 : (k == 1) ? 10 : (k == 2) ? 1 : 0;
    for (int p = 0; p < NPAGE; p++) begin
      logic v, w;
      v = (((p + k) % 3) != 0);
      w = (((p + k) % 2) == 0);
      expPpn[p] = PPN_W'((p * 7 + 3 + k) % 32);
      expAux[p] = {4'hA, 1'b0, v, w, 1'b0};
      poke(curBase + 2 * p, {3'b101, expPpn[p]});
      poke(curBase + 2 * p + 1, expAux[p]);
    end
    @(negedge clk);
    ptBase = MA_W'(curBase);
    ptLen  = LEN_W'(curLen);
  endtask

  task automatic doTxn(input int a, input bit wr, input bit fe, input bit pv);
    int lpn, off, expCause, expPhys, expLat, expRd, expWr, lat, r0, w0, ent;
    bit effWr, inRange;
    logic [WORD_W-1:0] na;
    string tag;
    lpn = a >> OFF_W; off = a % (1 << OFF_W);
    effWr = wr && !fe;
    ent = curBase + 2 * lpn;
    expCause = 0; expPhys = 0; expLat = 1; expRd = 0; expWr = 0; inRange = 0;
    if (pv) begin
      expPhys = a;
    end else if (lpn >= curLen) begin
      expCause = 1;
    end else begin
      inRange = 1; expRd = 2; expLat = 4;
      if (!expAux[lpn][2]) expCause = 2;
      else if (effWr && !expAux[lpn][1]) expCause = 3;
      else begin
        expPhys = int'(expPpn[lpn]) * (1 << OFF_W) + off;
        na = expAux[lpn] | 8'h08 | (effWr ? 8'h01 : 8'h00);
        if (na != expAux[lpn]) begin expWr = 1; expLat = 5; end
        expAux[lpn] = na;
      end
    end
    tag = pv ? "R1" : (expCause == 1) ? "R2" : (expCause == 2) ? "R4" :
          (expCause == 3 || fe) ? "R5" : "R3";

    r0 = rdCnt; w0 = wrCnt;
    @(negedge clk);
    chk(reqReady == 1'b1, "R8 ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqAddr = LA_W'(a); reqWrite = wr; reqFetch = fe; privMode = pv;
    @(posedge clk); #1;
    reqValid = 1'b0;
    lat = 1;
    if (!doneValid) chk(reqReady == 1'b0, "R8 busy not ready", int'(reqReady), 0);
    while (!doneValid && lat < 20) begin
      @(posedge clk); #1;
      lat++;
    end
    chk(lat == expLat, "R8 latency", lat, expLat);
    chk(int'(excCause) == expCause || expCause == 0 && !excValid, tag, int'(excCause), expCause);
    chk(excValid == (expCause != 0), tag, int'(excValid), int'(expCause != 0));
    if (expCause == 0)
      chk(int'(physAddr) == expPhys, tag, int'(physAddr), expPhys);
    @(posedge clk); #1;
    chk(doneValid == 1'b0, "R8 done pulse", int'(doneValid), 0);
    chk(rdCnt - r0 == expRd, pv ? "R1 no reads" : (expCause == 1) ? "R2 no reads" : "R3 reads",
        rdCnt - r0, expRd);
    chk(wrCnt - w0 == expWr, pv ? "R1 no writes" : "R7 write-back count", wrCnt - w0, expWr);
    if (inRange) begin
      chk(int'(prevRd) == ent % (1 << MA_W), "R3 entry word addr", int'(prevRd), ent);
      chk(int'(lastRd) == (ent + 1) % (1 << MA_W), "R3 aux word addr", int'(lastRd), ent + 1);
      chk(mem[MA_W'(ent + 1)] == expAux[lpn], (expCause != 0) ? "R7 aux untouched" : "R6 aux flags",
          int'(mem[MA_W'(ent + 1)]), int'(expAux[lpn]));
      if (expWr == 1)
        chk(int'(lastWr) == (ent + 1) % (1 << MA_W), "R6 write addr", int'(lastWr), ent + 1);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; privMode = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqFetch = 1'b0;
    reqAddr = '0; ptBase = '0; ptLen = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(reqReady == 1'b1, "R8 reset ready", int'(reqReady), 1);
    chk(doneValid == 1'b0, "R8 reset done", int'(doneValid), 0);
    chk(memEn == 1'b0, "R8 reset mem idle", int'(memEn), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < 4; k++) begin
      loadConfig(k);
      for (int a = 0; a < (1 << LA_W); a++) begin
        if (k % 2 == 0) begin
          doTxn(a, 1'b0, 1'b0, 1'b0);
          doTxn(a, 1'b1, 1'b0, 1'b0);
        end else begin
          doTxn(a, 1'b1, 1'b0, 1'b0);
          doTxn(a, 1'b0, 1'b0, 1'b0);
        end
        doTxn(a, 1'b1, 1'b1, 1'b0);
      end
      if (k == 1 || k == 3)
        for (int a = 0; a < (1 << LA_W); a++)
          doTxn(a, a[0], 1'b0, 1'b1);
    end

    summary();
    $finish;
  end

endmodule